// File: doc/BRIEF.md
# Pixel-Path Diagnostic Register Port

This block is a byte-wide pixel path with a small diagnostic register port beside it. Bytes that arrive from video memory with a valid strobe are registered once. On the next cycle they are driven to a palette DAC, together with a pixel strobe and an output enable. Next to this path sit two snoop registers. One holds the last byte taken from the memory input. The other holds the last byte actually driven to the DAC.

Software reaches the diagnostic space through an index/data pair on the I/O bus. It first writes a test index to the index address, then reads or writes the data address. Two indices are read-only and return the snooped bytes. One index is write-only and holds a test control byte. That byte can hold the pixel path in a hard reset, blank the DAC bus and suppress the pixel strobe. Only the external reset clears the control byte and the index.

Top module: `pix_diag_port`

## Requirements
- R1: After the asynchronous reset `rst_ni`, the index reads 0, both snoop registers read 0, `dac_pix_o` is 0, `dac_stb_o` is 0 and `dac_oe_o` is 1.
- R2: A write to I/O address 0x19 loads the test index, reading 0x19 returns it, and it keeps its value across any number of accesses to the data address 0x18.
- R3: A byte presented with `vram_valid_i` high appears on `dac_pix_o` with `dac_stb_o` high one clock later. When `vram_valid_i` is low, `dac_pix_o` keeps its last byte and `dac_stb_o` is low.
- R4: Reading 0x18 with index 2 returns the last byte accepted on the memory input while `vram_valid_i` was high. It is updated at the clock edge that accepts the byte.
- R5: Reading 0x18 with index 1 returns the last byte driven to the DAC with output enable high. It is updated one clock after the byte appears on `dac_pix_o`.
- R6: Reading 0x18 with index 4 (write-only) or with any index other than 1, 2 or 4 returns 0xFF. Reading any address other than 0x18 or 0x19 also returns 0xFF.
- R7: A write to 0x18 with any index other than 4 changes neither the snoop registers, the pixel path nor the control byte.
- R8: With control bit 0 set (written at index 4), the clock edges after the write clear the pixel register, its strobe and both snoop registers, and hold them clear for as long as the bit stays 1. Normal operation resumes once the bit is written back to 0.
- R9: With control bit 1 set, `dac_pix_o` is 0 and `dac_oe_o` is 0, and the index 1 snoop register is not loaded.
- R10: With control bit 2 set, `dac_stb_o` is held low. Bits 7 to 3 are stored but have no output to act on.
- R11: The hard reset of R8 does not clear the control byte or the index. Control bit 1 keeps `dac_oe_o` low throughout a hard reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_addr_i | input | 10 | I/O address |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, combinational from address, index and state |
| vram_data_i | input | 8 | Byte from video memory |
| vram_valid_i | input | 1 | Qualifies `vram_data_i` |
| dac_pix_o | output | 8 | Pixel byte to the DAC |
| dac_stb_o | output | 1 | Pixel strobe to the DAC |
| dac_oe_o | output | 1 | Output enable for the DAC bus |

## Verification
Read data is combinational, so an index or address change shows on `io_rdata_o` in the same cycle. A register written at an edge is seen at that edge's output. A memory byte reaches `dac_pix_o` and the index 2 snoop after the edge that accepts it, and reaches the index 1 snoop after one further edge. A control write acts from the edge after it, and the hard reset clears state at the edge after that. The bench's reference model advances on each rising edge with the same input values the design sees. Every comparison and every directed read is taken a few nanoseconds after a rising edge, while the inputs are still stable, so each expected value already includes exactly these edges.

// File: rtl/pix_diag_pkg.sv
package pix_diag_pkg;
  localparam int unsigned BYTE_W = 8;

  // test index values decoded by the data register
  localparam logic [BYTE_W-1:0] TIDX_DAC_SNOOP  = 8'd1;
  localparam logic [BYTE_W-1:0] TIDX_VRAM_SNOOP = 8'd2;
  localparam logic [BYTE_W-1:0] TIDX_CTRL       = 8'd4;

  // control byte bit positions
  localparam int unsigned CTL_HARD_RST = 0;
  localparam int unsigned CTL_DAC_OFF  = 1;
  localparam int unsigned CTL_STB_OFF  = 2;

  localparam logic [BYTE_W-1:0] RD_IDLE = '1;

  localparam int unsigned N_SNOOP = 2;
  localparam int unsigned SNP_DAC  = 0;
  localparam int unsigned SNP_VRAM = 1;
endpackage

// File: rtl/pix_diag_regs.sv
module pix_diag_regs
  import pix_diag_pkg::*;
#(
  parameter int unsigned AW        = 10,
  parameter logic [AW-1:0] IDX_ADDR  = 10'h019,
  parameter logic [AW-1:0] DATA_ADDR = 10'h018
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] snp_dac_i,
  input  logic [BYTE_W-1:0] snp_vram_i,
  output logic [BYTE_W-1:0] idx_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] idx_q, ctrl_q;
  logic sel_idx, sel_data;

  assign sel_idx  = (addr_i == IDX_ADDR);
  assign sel_data = (addr_i == DATA_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      if (sel_idx) idx_q <= wdata_i;
      if (sel_data && idx_q == TIDX_CTRL) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = RD_IDLE;
    if (sel_idx) begin
      rdata_o = idx_q;
    end else if (sel_data) begin
      unique case (idx_q)
        TIDX_DAC_SNOOP:  rdata_o = snp_dac_i;
        TIDX_VRAM_SNOOP: rdata_o = snp_vram_i;
        default:         rdata_o = RD_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pix_stage.sv
module pix_stage
  import pix_diag_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hard_rst_i,
  input  logic          dac_off_i,
  input  logic          stb_off_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic [DW-1:0] dac_pix_o,
  output logic          dac_stb_o,
  output logic          dac_oe_o,
  output logic          drv_valid_o,
  output logic [DW-1:0] pix_o
);
  logic [DW-1:0] pix_q;
  logic          pv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q <= '0;
      pv_q  <= 1'b0;
    end else if (hard_rst_i) begin
      pix_q <= '0;
      pv_q  <= 1'b0;
    end else begin
      pv_q <= in_valid_i;
      if (in_valid_i) pix_q <= in_data_i;
    end
  end

  assign dac_pix_o   = dac_off_i ? '0 : pix_q;
  assign dac_oe_o    = ~dac_off_i;
  assign dac_stb_o   = pv_q & ~stb_off_i;
  assign drv_valid_o = pv_q & ~dac_off_i;
  assign pix_o       = pix_q;
endmodule

// File: rtl/snoop_reg.sv
module snoop_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (clr_i)  q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/pix_diag_port.sv
module pix_diag_port
  import pix_diag_pkg::*;
#(
  parameter int unsigned AW        = 10,
  parameter logic [AW-1:0] IDX_ADDR  = 10'h019,
  parameter logic [AW-1:0] DATA_ADDR = 10'h018
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     io_addr_i,
  input  logic              io_wr_i,
  input  logic [BYTE_W-1:0] io_wdata_i,
  output logic [BYTE_W-1:0] io_rdata_o,
  input  logic [BYTE_W-1:0] vram_data_i,
  input  logic              vram_valid_i,
  output logic [BYTE_W-1:0] dac_pix_o,
  output logic              dac_stb_o,
  output logic              dac_oe_o
);
  logic [BYTE_W-1:0] idx_q, ctrl_q, pix_q;
  logic              drv_valid;
  logic [BYTE_W-1:0] snp_d [N_SNOOP];
  logic              snp_ld [N_SNOOP];
  logic [BYTE_W-1:0] snp_q [N_SNOOP];

  pix_diag_regs #(
    .AW(AW), .IDX_ADDR(IDX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (io_addr_i),
    .wr_i      (io_wr_i),
    .wdata_i   (io_wdata_i),
    .snp_dac_i (snp_q[SNP_DAC]),
    .snp_vram_i(snp_q[SNP_VRAM]),
    .idx_o     (idx_q),
    .ctrl_o    (ctrl_q),
    .rdata_o   (io_rdata_o)
  );

  pix_stage #(.DW(BYTE_W)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hard_rst_i (ctrl_q[CTL_HARD_RST]),
    .dac_off_i  (ctrl_q[CTL_DAC_OFF]),
    .stb_off_i  (ctrl_q[CTL_STB_OFF]),
    .in_data_i  (vram_data_i),
    .in_valid_i (vram_valid_i),
    .dac_pix_o  (dac_pix_o),
    .dac_stb_o  (dac_stb_o),
    .dac_oe_o   (dac_oe_o),
    .drv_valid_o(drv_valid),
    .pix_o      (pix_q)
  );

  assign snp_d[SNP_DAC]   = pix_q;
  assign snp_ld[SNP_DAC]  = drv_valid;
  assign snp_d[SNP_VRAM]  = vram_data_i;
  assign snp_ld[SNP_VRAM] = vram_valid_i;

  for (genvar g = 0; g < N_SNOOP; g++) begin : g_snoop
    snoop_reg #(.DW(BYTE_W)) u_snp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (ctrl_q[CTL_HARD_RST]),
      .load_i(snp_ld[g]),
      .d_i   (snp_d[g]),
      .q_o   (snp_q[g])
    );
  end
endmodule

// File: rtl/pix_diag_port_chk.sv
module pix_diag_port_chk #(
  parameter int unsigned AW = 10,
  parameter logic [AW-1:0] DATA_ADDR = 10'h018
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] io_addr_i,
  input logic          io_wr_i,
  input logic [7:0]    io_rdata_o,
  input logic [7:0]    vram_data_i,
  input logic          vram_valid_i,
  input logic [7:0]    dac_pix_o,
  input logic          dac_stb_o,
  input logic          dac_oe_o,
  input logic [7:0]    idx_q,
  input logic [7:0]    ctrl_q,
  input logic [7:0]    pix_q,
  input logic [7:0]    snp_dac,
  input logic [7:0]    snp_vram
);
  p_idx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> $stable(idx_q));

  p_vram_snoop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_valid_i && !ctrl_q[0]) |=> snp_vram == $past(vram_data_i));

  p_pix_path_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_valid_i && !ctrl_q[0]) |=> pix_q == $past(vram_data_i));

  p_wo_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i == DATA_ADDR && idx_q == 8'd4) |-> io_rdata_o == 8'hFF);

  p_hard_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctrl_q[0]) |-> (snp_dac == 8'h00 && snp_vram == 8'h00 && !dac_stb_o));

  p_dac_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[1] |-> (dac_pix_o == 8'h00 && !dac_oe_o));

  p_dac_off_nosnoop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[1] |=> $stable(snp_dac) || snp_dac == 8'h00);

  p_stb_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[2] |-> !dac_stb_o);
endmodule

bind pix_diag_port pix_diag_port_chk #(.AW(AW), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_addr_i   (io_addr_i),
  .io_wr_i     (io_wr_i),
  .io_rdata_o  (io_rdata_o),
  .vram_data_i (vram_data_i),
  .vram_valid_i(vram_valid_i),
  .dac_pix_o   (dac_pix_o),
  .dac_stb_o   (dac_stb_o),
  .dac_oe_o    (dac_oe_o),
  .idx_q       (idx_q),
  .ctrl_q      (ctrl_q),
  .pix_q       (pix_q),
  .snp_dac     (snp_q[0]),
  .snp_vram    (snp_q[1])
);

// File: tb/sim_pix_diag_port.sv
`timescale 1ns/1ps
module sim_pix_diag_port;
  localparam logic [9:0] A_IDX  = 10'h019;
  localparam logic [9:0] A_DATA = 10'h018;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] vd = '0;
  logic       vv = 1'b0;
  logic [7:0] dpix;
  logic       dstb, doe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pix_diag_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .vram_data_i(vd),
    .vram_valid_i(vv), .dac_pix_o(dpix), .dac_stb_o(dstb), .dac_oe_o(doe)
  );

  // behavioural reference
  int m_idx, m_ctl, m_pix, m_pv, m_sd, m_sv;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx <= 0; m_ctl <= 0; m_pix <= 0; m_pv <= 0; m_sd <= 0; m_sv <= 0;
    end else begin
      if (wr && addr == A_IDX) m_idx <= wdata;
      if (wr && addr == A_DATA && m_idx == 4) m_ctl <= wdata;
      if (m_ctl % 2 == 1) begin
        m_pix <= 0; m_pv <= 0; m_sd <= 0; m_sv <= 0;
      end else begin
        m_pv <= vv;
        if (vv) begin m_pix <= vd; m_sv <= vd; end
        if (m_pv == 1 && ((m_ctl / 2) % 2) == 0) m_sd <= m_pix;
      end
    end
  end

  function automatic int exp_rd();
    if (addr == A_IDX) return m_idx;
    if (addr != A_DATA) return 255;
    if (m_idx == 1) return m_sd;
    if (m_idx == 2) return m_sv;
    return 255;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison, a few ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      automatic bit off = ((m_ctl / 2) % 2) == 1;
      automatic int e_pix = off ? 0 : m_pix;
      automatic int e_stb = (m_pv == 1 && ((m_ctl / 4) % 2) == 0) ? 1 : 0;
      chk(int'(dpix) == e_pix, "R3/R9 dac_pix_o", dpix, e_pix);
      chk(int'(dstb) == e_stb, "R3/R10 dac_stb_o", dstb, e_stb);
      chk(doe == !off, "R9/R11 dac_oe_o", doe, !off);
      chk(int'(rdata) == exp_rd(), "R2/R4/R5/R6 io_rdata_o", rdata, exp_rd());
    end
  end

  task automatic io_wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(logic [9:0] a, logic [7:0] e, string tag);
    @(negedge clk); addr = a;
    #2 chk(rdata == e, tag, rdata, e);
  endtask

  task automatic px(logic [7:0] d, logic v);
    @(negedge clk); vd = d; vv = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    addr = A_IDX;
    #1 chk(rdata == 8'h00, "R1 index after reset", rdata, 0);
    chk(dpix == 8'h00 && !dstb && doe, "R1 dac outputs after reset", {dpix, dstb, doe}, 1);

    io_wr(A_IDX, 8'h02);
    rd_chk(A_IDX, 8'h02, "R2 index readback");
    rd_chk(A_DATA, 8'h00, "R1 vram snoop after reset");
    io_wr(A_IDX, 8'h01);
    rd_chk(A_DATA, 8'h00, "R1 dac snoop after reset");

    px(8'h11, 1); px(8'h22, 1); px(8'h33, 1); px(8'h77, 0); px(8'h00, 0);
    rd_chk(A_DATA, 8'h33, "R5 dac snoop last driven");
    rd_chk(A_DATA, 8'h33, "R2 index kept across data reads");
    io_wr(A_IDX, 8'h02);
    rd_chk(A_DATA, 8'h33, "R4 vram snoop ignores invalid byte");

    // writes to read-only / undefined indices
    io_wr(A_DATA, 8'h5A);
    rd_chk(A_DATA, 8'h33, "R7 write to index 2 ignored");
    io_wr(A_IDX, 8'h07); io_wr(A_DATA, 8'hFF);
    chk(doe && dpix == 8'h33, "R7 write to index 7 ignored", {dpix, doe}, 16'h331);
    io_wr(A_IDX, 8'h01); io_wr(A_DATA, 8'h03);
    rd_chk(A_DATA, 8'h33, "R7 write to index 1 ignored");
    chk(doe, "R7 ctrl untouched", doe, 1);

    // reads of write-only / undefined
    io_wr(A_IDX, 8'h04);
    rd_chk(A_DATA, 8'hFF, "R6 read of write-only index");
    io_wr(A_IDX, 8'h00);
    rd_chk(A_DATA, 8'hFF, "R6 read of index 0");
    io_wr(A_IDX, 8'hC3);
    rd_chk(A_DATA, 8'hFF, "R6 read of index C3");
    rd_chk(10'h300, 8'hFF, "R6 read of other address");

    // DAC bus disable
    io_wr(A_IDX, 8'h04); io_wr(A_DATA, 8'h02);
    px(8'h44, 1); px(8'h00, 0);
    @(negedge clk);
    chk(dpix == 8'h00 && !doe, "R9 dac bus blanked", {dpix, doe}, 0);
    io_wr(A_IDX, 8'h01);
    rd_chk(A_DATA, 8'h33, "R9 dac snoop not loaded while blanked");
    io_wr(A_IDX, 8'h02);
    rd_chk(A_DATA, 8'h44, "R4 vram snoop while blanked");

    // strobe disable
    io_wr(A_IDX, 8'h04); io_wr(A_DATA, 8'h04);
    px(8'h55, 1); px(8'h66, 1);
    #2 chk(!dstb && dpix == 8'h55, "R10 strobe held low", {dpix, dstb}, 16'h550);
    px(8'h00, 0);

    // hard reset with DAC disable
    io_wr(A_DATA, 8'h03);
    px(8'h88, 1); px(8'h99, 1); px(8'h00, 0);
    #2 chk(!doe && dpix == 8'h00 && !dstb, "R11 oe stays low in hard reset", {dpix, dstb, doe}, 0);
    io_wr(A_IDX, 8'h02);
    rd_chk(A_DATA, 8'h00, "R8 vram snoop held clear");
    io_wr(A_IDX, 8'h01);
    rd_chk(A_DATA, 8'h00, "R8 dac snoop held clear");
    rd_chk(A_IDX, 8'h01, "R11 index survives hard reset");

    // release
    io_wr(A_IDX, 8'h04); io_wr(A_DATA, 8'h00);
    px(8'hA5, 1); px(8'h00, 0);
    #2 chk(dpix == 8'hA5 && dstb && doe, "R8 path resumes after release", {dpix, dstb, doe}, 16'hA511);
    io_wr(A_IDX, 8'h01);
    rd_chk(A_DATA, 8'hA5, "R5 dac snoop after release");

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule